// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block is a synchronous reset supervisor for a processor subsystem. It combines three reset sources. The first is a power-on delay that starts once the supply is reported good. The second is an immediate reset whenever the supply-good flag drops. The third is a watchdog timer that the monitored processor must service by pulling a kick line low at regular intervals. An external comparator judges the supply, and its result arrives here as a synchronised flag.

All three intervals come from a single scale parameter, in the ratio 50:50:1. The power-on delay and the monitoring window are each 50 × SCALE clock cycles, and the watchdog reset pulse is SCALE cycles. When the watchdog times out, the block emits one fixed-width pulse, then re-arms and keeps monitoring. The watchdog can be switched off with an enable input. Supply and power-on reset remain active while it is off. The block drives two reset outputs of opposite polarity.

Top module: `wdog_supervisor`

## Requirements
- R1: While the synchronous reset input `rst_n` is low at a rising edge, the block enters the power-on hold state. After that edge, `rst_hi` is 1 and `rst_lo` is 0.
- R2: Once `supply_ok` is high, `rst_hi` stays 1 for exactly POR_CYC = 50·SCALE rising edges. It falls after the POR_CYC-th edge.
- R3: In monitoring with `wd_en` high, if no kick is recognised for WIN_CYC = 50·SCALE edges, `rst_hi` rises after the WIN_CYC-th edge. This window is counted from entry into monitoring or from the last recognised kick.
- R4: A watchdog reset pulse lasts exactly PULSE_CYC = SCALE edges. After it, the timer restarts from zero, so the next timeout follows WIN_CYC edges later.
- R5: While `wd_en` is low, no watchdog reset occurs and the timer is held at zero. After re-enabling, the full WIN_CYC window applies.
- R6: A low `supply_ok` drives `rst_hi` to 1 in the same cycle, without waiting for a clock edge. Each edge at which `supply_ok` is low restarts the power-on delay, so a full POR_CYC follows recovery. This holds even if the drop occurs during the delay itself.
- R7: `kick` passes through a two-flop synchroniser. A falling edge counts as a kick once the synchronised level has been low for KICK_MIN_LOW edges. A kick that falls just after edge 0 clears the timer at edge KICK_MIN_LOW+2, so the timeout follows at edge KICK_MIN_LOW+2+WIN_CYC.
- R8: A low level on `kick` shorter than KICK_MIN_LOW cycles is ignored, and the timeout keeps its earlier schedule.
- R9: `rst_lo` is always the inverse of `rst_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| supply_ok | input | 1 | Synchronised supply-good flag |
| wd_en | input | 1 | Watchdog enable, 1 = watchdog active |
| kick | input | 1 | Service line from the monitored processor, asynchronous |
| rst_hi | output | 1 | Reset output, high while in reset |
| rst_lo | output | 1 | Reset output, low while in reset |

## Verification
The bench builds the block with SCALE = 4 and KICK_MIN_LOW = 3. This gives a 200-cycle power-on delay, a 200-cycle window and a 4-cycle pulse. With these values, every timeout, pulse end and kick-filter edge can be checked on its exact cycle, both before and after the boundary, within a short run. The small KICK_MIN_LOW lets a two-cycle kick fall below the filter while a held kick passes it. This exercises both sides of the glitch rejection.

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int SCALE        = 2000,
  parameter int POR_UNITS    = 50,
  parameter int WIN_UNITS    = 50,
  parameter int PULSE_UNITS  = 1,
  parameter int KICK_MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wd_en,
  input  logic kick,
  output logic rst_hi,
  output logic rst_lo
);
  localparam int POR_CYC   = POR_UNITS * SCALE;
  localparam int WIN_CYC   = WIN_UNITS * SCALE;
  localparam int PULSE_CYC = PULSE_UNITS * SCALE;
  localparam int MAX_CYC   = (POR_CYC > WIN_CYC) ? POR_CYC : WIN_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);
  localparam int LW        = $clog2(KICK_MIN_LOW + 1);
  localparam logic [CW-1:0] POR_LAST   = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] WIN_LAST   = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [LW-1:0] LOW_LAST   = LW'(KICK_MIN_LOW - 1);
  localparam logic [LW-1:0] LOW_SAT    = LW'(KICK_MIN_LOW);

  typedef enum logic [1:0] {POR_HOLD, MONITOR, WDT_PULSE} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [1:0]      ksync;
  logic [LW-1:0]   low_run;
  logic            kick_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) ksync <= 2'b11;
    else        ksync <= {ksync[0], kick};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ksync[1])   low_run <= '0;
    else if (low_run != LOW_SAT) low_run <= low_run + 1'b1;
  end

  assign kick_evt = !ksync[1] && (low_run == LOW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !supply_ok) begin
      state <= POR_HOLD;
      cnt   <= '0;
    end else begin
      case (state)
        POR_HOLD:
          if (cnt == POR_LAST) begin
            state <= MONITOR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        MONITOR:
          if (!wd_en || kick_evt) cnt <= '0;
          else if (cnt == WIN_LAST) begin
            state <= WDT_PULSE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        WDT_PULSE:
          if (cnt == PULSE_LAST) begin
            state <= MONITOR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        default: begin
          state <= POR_HOLD;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign rst_hi = (state != MONITOR) || !supply_ok;
  assign rst_lo = !rst_hi;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int MIN_W = 1
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic wd_en,
  input logic rst_hi,
  input logic rst_lo
);
  int hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)      hi_run <= 0;
    else if (rst_hi) hi_run <= (hi_run < MIN_W) ? hi_run + 1 : hi_run;
    else             hi_run <= 0;
  end

  assert_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_lo != rst_hi);

  assert_supply_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> rst_hi);

  assert_por_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |=> rst_hi);

  assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_hi) |-> hi_run >= MIN_W);

  assert_wd_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !wd_en && $past(!wd_en) && $past(!rst_hi)) |-> !rst_hi);
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.MIN_W(PULSE_UNITS * SCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_en(wd_en),
  .rst_hi(rst_hi), .rst_lo(rst_lo)
);

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb;
  localparam int SCALE = 4;
  localparam int KMIN  = 3;
  localparam int P     = 50 * SCALE;
  localparam int W     = 50 * SCALE;
  localparam int PW    = SCALE;

  logic clk = 0, rst_n = 0, supply_ok = 0, wd_en = 1, kick = 1;
  logic rst_hi, rst_lo;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  wdog_supervisor #(.SCALE(SCALE), .KICK_MIN_LOW(KMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_en(wd_en),
    .kick(kick), .rst_hi(rst_hi), .rst_lo(rst_lo)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic exp);
    tests++;
    if (rst_hi !== exp || rst_lo !== !exp) begin
      fails++;
      $display("FAIL %s: rst_hi=%b rst_lo=%b expected rst_hi=%b rst_lo=%b",
               req, rst_hi, rst_lo, exp, !exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 0; supply_ok = 0;
    step(3);
    chk("R1", 1'b1);
    rst_n = 1;
  endtask

  task automatic t_por;
    supply_ok = 1;
    step(P - 1); chk("R2", 1'b1);
    step(1);     chk("R2 R9", 1'b0);
  endtask

  task automatic t_timeout;
    step(W - 1); chk("R3", 1'b0);
    step(1);     chk("R3", 1'b1);
  endtask

  task automatic t_pulse;
    step(PW - 1); chk("R4", 1'b1);
    step(1);      chk("R4", 1'b0);
    step(W - 1);  chk("R4", 1'b0);
    step(1);      chk("R4", 1'b1);
    step(PW);     chk("R4", 1'b0);
  endtask

  task automatic t_kick;
    kick = 0;
    step(KMIN + 1 + W); chk("R7", 1'b0);
    step(1);            chk("R7", 1'b1);
    kick = 1;
    step(PW);           chk("R7", 1'b0);
  endtask

  task automatic t_short_kick;
    kick = 0;
    step(KMIN - 1);
    kick = 1;
    step(W - KMIN); chk("R8", 1'b0);
    step(1);        chk("R8", 1'b1);
    step(PW);       chk("R8", 1'b0);
  endtask

  task automatic t_disable;
    wd_en = 0;
    step(2 * W);  chk("R5", 1'b0);
    wd_en = 1;
    step(W - 1);  chk("R5", 1'b0);
    step(1);      chk("R5", 1'b1);
    step(PW);     chk("R5", 1'b0);
  endtask

  task automatic t_supply;
    step(10);
    supply_ok = 0;
    #1;           chk("R6", 1'b1);
    step(5);      chk("R6", 1'b1);
    supply_ok = 1;
    step(P / 2);  chk("R6", 1'b1);
    supply_ok = 0;
    step(3);
    supply_ok = 1;
    step(P - 1);  chk("R6", 1'b1);
    step(1);      chk("R6", 1'b0);
    step(W - 1);  chk("R3", 1'b0);
    step(1);      chk("R3", 1'b1);
  endtask

  initial begin
    t_reset();
    t_por();
    t_timeout();
    t_pulse();
    t_kick();
    t_short_kick();
    t_disable();
    t_supply();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule